// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital part of a synthesizer feedback path built around an external dual-modulus prescaler. It is clocked by the prescaler's output pulses. It holds a programmable main count N and a swallow count A, and it drives the prescaler's modulus-select line. For the first A prescaler-output clocks of each division cycle the prescaler is told to divide by 65. For the remaining N - A clocks it is told to divide by 64. One division cycle therefore spans 64·N + A cycles of the oscillator that feeds the prescaler.

At the end of each cycle the block emits a single-clock comparison pulse for the phase detector. Both counters then reload from the N and A values presented on the inputs. A transmit loop and a receive loop each use their own instance, with independent N and A. N runs from 16 to 2047, A from 0 to 127, and A must stay below N.

Top module: `pswallow_divider`

## Requirements
- R1: With N and A held steady, the number of oscillator cycles between two consecutive comparison pulses is 64·N + A. Each clock in which `mod_sel` is 1 accounts for 65 oscillator cycles, and each clock in which it is 0 accounts for 64.
- R2: While enabled, `cmp_pulse` is 1 for exactly one clock in every N clocks, and is 0 in the other clocks.
- R3: Within each division cycle, `mod_sel` is 1 in exactly the first A clocks and 0 in the rest. It never returns to 1 before the next cycle starts.
- R4: When A = 0, `mod_sel` stays 0 for the whole cycle.
- R5: In the clock in which `cmp_pulse` is 1, `mod_sel` is 0, given A < N.
- R6: Changes to `n_val` or `a_val` do not alter the cycle in progress. They are captured only at the clock edge that ends the pulse clock.
- R7: A synchronous active-low `rst_n` forces both outputs to 0. After `rst_n` (or `en`) is sampled high, the first clock is clock 0 of a fresh cycle, so the first pulse appears in the N-th clock.
- R8: While `en` is low (from the clock after it is sampled low), both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider parked at a cycle start |
| n_val | input | 11 | Main count N (16..2047) |
| a_val | input | 7 | Swallow count A (0..127, below N) |
| mod_sel | output | 1 | 1 = prescaler divides by 65, 0 = by 64 |
| cmp_pulse | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
The bench models the prescaler by weighting each clock at 64 or 65 oscillator cycles according to `mod_sel`, and compares each measured period to 64·N + A. It covers the extremes N = 16 and N = 2047, A = 0, A = 127, and A = N - 1. An off-by-one in either counter would show up as a period that is wrong by 64 or 1. A swallow counter that wraps instead of stopping would re-raise `mod_sel` late in the cycle. A design that takes new N or A immediately would change the length of the cycle in progress. The bench also counts clocks from reset release to the first pulse, which exposes any extra or missing start-up cycle.

// File: rtl/pswd_pkg.sv
// Package: shared widths and constants for the pulse-swallow divider.
// Assumes the external prescaler divides by PRESC_M or PRESC_M + 1.
package pswd_pkg;
    localparam int MAIN_W    = 11;  // width of main count N
    localparam int SWALLOW_W = 7;   // width of swallow count A
    localparam int PRESC_M   = 64;  // low modulus of the prescaler
    localparam int N_MIN     = 16;  // smallest legal N
endpackage

// File: rtl/pswd_swallow_ctr.sv
// Swallow counter: loads A at the start of a cycle, then counts down once per
// clock and parks at zero. 'active' is high while count remains, which is
// the interval the prescaler must divide by the high modulus.
// Assumes load and step are never both high.
module pswd_swallow_ctr #(
    parameter int W = pswd_pkg::SWALLOW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic         active
);
    logic [W-1:0] cnt;

    // Count register: clear on reset, load at cycle start, decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Status: swallow phase lasts while the count is nonzero.
    always_comb active = (cnt != '0);

    AST_SWALLOW_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
    AST_SWALLOW_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load && cnt == '0) |=> (cnt == '0)); // R3
endmodule

// File: rtl/pswd_main_ctr.sv
// Main programmable counter: loads N-1 at the start of a cycle and counts down
// once per clock; 'terminal' marks the last clock of the cycle, so a cycle is
// exactly N clocks. Assumes N is at least N_MIN, so N-1 never underflows.
module pswd_main_ctr #(
    parameter int W = pswd_pkg::MAIN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic         terminal
);
    logic [W-1:0] cnt;
    logic [W-1:0] start_val;

    // Start value: a cycle of N clocks runs the count from N-1 down to 0.
    always_comb start_val = load_val - 1'b1;

    // Count register: clear on reset, load at cycle start, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= start_val;
        else if (step)
            cnt <= cnt - 1'b1;
    end

    // Terminal detect: last clock of the division cycle.
    always_comb terminal = (cnt == '0);

    AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && load) |=> (cnt == $past(load_val) - 1'b1)); // R6
    AST_MAIN_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step && !load) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/pswallow_divider.sv
// Pulse-swallow feedback divider top. Runs a main counter for N clocks and a
// swallow counter for the first A of them, asserting mod_sel (divide by 65)
// during the swallow phase and emitting cmp_pulse in the last clock. Total
// ratio is PRESC_M*N + A oscillator cycles. Assumes 16 <= N, A < N, and that
// n_val/a_val are stable at the edge ending each pulse clock.
module pswallow_divider #(
    parameter int MAIN_W    = pswd_pkg::MAIN_W,
    parameter int SWALLOW_W = pswd_pkg::SWALLOW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [MAIN_W-1:0]    n_val,
    input  logic [SWALLOW_W-1:0] a_val,
    output logic                 mod_sel,
    output logic                 cmp_pulse
);
    logic running;
    logic main_term;
    logic sw_active;
    logic ctr_load;
    logic ctr_step;

    // Run flag: one clock after en is sampled high the first cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else
            running <= en;
    end

    // Sequencing: reload while parked or at the terminal clock, else advance.
    always_comb begin
        ctr_load = !running || main_term;
        ctr_step = running && !main_term;
    end

    pswd_main_ctr #(.W(MAIN_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .step     (ctr_step),
        .load_val (n_val),
        .terminal (main_term)
    );

    pswd_swallow_ctr #(.W(SWALLOW_W)) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .step     (ctr_step),
        .load_val (a_val),
        .active   (sw_active)
    );

    // Outputs: both gated by the run flag so a parked divider is silent.
    always_comb begin
        mod_sel   = running && sw_active;
        cmp_pulse = running && main_term;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cmp_pulse) |=> !cmp_pulse); // R2
    AST_MOD_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && running && !mod_sel && !main_term) |=> !mod_sel); // R3
    AST_MOD_LOW_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pulse && a_val < n_val) |-> !mod_sel); // R5
    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> (!mod_sel && !cmp_pulse)); // R8
endmodule

// File: tb/pswallow_divider_tb.sv
// Bench: weights each clock at 64 or 65 oscillator cycles from mod_sel and
// checks period, clock count and swallow-phase shape against N and A.
module pswallow_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [10:0] n_val;
    logic [6:0]  a_val;
    logic        mod_sel;
    logic        cmp_pulse;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pswallow_divider u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .n_val(n_val), .a_val(a_val),
        .mod_sel(mod_sel), .cmp_pulse(cmp_pulse)
    );

    // {N, A} pairs
    localparam logic [17:0] VEC [8] = '{
        {11'd16,   7'd0},   {11'd16,  7'd15},  {11'd100, 7'd37},
        {11'd2047, 7'd127}, {11'd128, 7'd127}, {11'd500, 7'd1},
        {11'd17,   7'd16},  {11'd64,  7'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the sample in which the pulse is seen.
    task automatic wait_pulse();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cmp_pulse && guard < 5000);
    endtask

    // Measure one cycle starting at the next sample, ending at the pulse.
    task automatic measure(output int clks, output int vco, output int highs, output bit shape_ok);
        bit seen_low = 1'b0;
        clks = 0; vco = 0; highs = 0; shape_ok = 1'b1;
        forever begin
            @(negedge clk);
            clks++;
            vco += mod_sel ? 65 : 64;
            if (mod_sel) begin
                highs++;
                if (seen_low) shape_ok = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            if (cmp_pulse || clks > 5000) break;
        end
    endtask

    initial begin
        int clks, vco, highs, cnt;
        bit ok;
        rst_n = 1'b0; en = 1'b1; n_val = 11'd20; a_val = 7'd5;
        repeat (3) @(negedge clk);
        check(!mod_sel && !cmp_pulse, "R7 reset outputs", {mod_sel, cmp_pulse}, 0);

        // R7: first pulse lands in the N-th clock after reset release
        rst_n = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!cmp_pulse && cnt < 100);
        check(cnt == 20, "R7 first pulse clock", cnt, 20);

        // Vector table walk: R1 period, R2 clock count, R3/R4 swallow phase
        foreach (VEC[i]) begin
            n_val = VEC[i][17:7];
            a_val = VEC[i][6:0];
            wait_pulse();
            measure(clks, vco, highs, ok);
            check(vco == 64 * int'(VEC[i][17:7]) + int'(VEC[i][6:0]), "R1 period",
                  vco, 64 * int'(VEC[i][17:7]) + int'(VEC[i][6:0]));
            check(clks == int'(VEC[i][17:7]), "R2 clocks per pulse", clks, int'(VEC[i][17:7]));
            check(highs == int'(VEC[i][6:0]) && ok, VEC[i][6:0] == 0 ? "R4 no swallow" : "R3 swallow phase",
                  highs, int'(VEC[i][6:0]));
        end

        // R5: mod_sel low in the pulse clock when A = N-1
        n_val = 11'd40; a_val = 7'd39;
        wait_pulse();
        wait_pulse();
        check(!mod_sel, "R5 mod_sel at pulse", mod_sel, 0);

        // R6: mid-cycle change leaves the running cycle alone
        n_val = 11'd40; a_val = 7'd10;
        wait_pulse();
        wait_pulse();
        @(negedge clk);
        vco = mod_sel ? 65 : 64;
        n_val = 11'd30; a_val = 7'd3;
        measure(clks, cnt, highs, ok);
        check(vco + cnt == 64 * 40 + 10, "R6 old cycle kept", vco + cnt, 64 * 40 + 10);
        measure(clks, vco, highs, ok);
        check(vco == 64 * 30 + 3, "R6 new values at reload", vco, 64 * 30 + 3);

        // R8: parked divider stays silent
        en = 1'b0;
        @(negedge clk);
        cnt = 0;
        repeat (60) begin
            @(negedge clk);
            if (mod_sel || cmp_pulse) cnt++;
        end
        check(cnt == 0, "R8 outputs while disabled", cnt, 0);

        // R7: restart via en gives a fresh cycle, first pulse in clock N
        n_val = 11'd25; a_val = 7'd7;
        en = 1'b1;
        measure(clks, vco, highs, ok);
        check(clks == 25, "R7 restart first pulse", clks, 25);
        check(vco == 64 * 25 + 7, "R1 period after restart", vco, 64 * 25 + 7);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule